// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers 36-bit words between a writer and a reader that run on unrelated clocks. The word storage is an inferred two-port memory whose depth is a power of two. Each side keeps its own binary pointer. The pointer crosses to the other clock domain as Gray code through a two-stage synchroniser, and an extra wrap bit tells a full memory apart from an empty one. The write side reports full and half-full. Both sides report almost-empty and almost-full against two offsets that can be changed at run time.

A master reset captures three things from plain inputs: the output timing style, the almost-flag timing style and a 3-bit preset index that sets both offsets. Software can then replace the offsets. It can write them as two parallel words on the data bus, or shift them in one bit per write clock. A partial reset empties the buffer but keeps the offsets and the captured modes. The read port has two timing styles. In standard timing the read enable pulls each word onto the output register. In fall-through timing the oldest word is placed on the output register without any request. A retransmit input rewinds the read side to the first word written since reset, with no added latency.

Back-pressure rules: a write is taken on a write-clock edge with `wr_en` high and `ld` low, only while the buffer has room. Room means `wr_flag` is low in standard timing, or high in fall-through timing. In fall-through timing the read port behaves as valid/ready. `rd_flag` is the valid signal, `dout` holds the data, and `rd_en` is the ready signal that consumes the word on a read-clock edge. In standard timing, `rd_flag` is the empty indication and `rd_en` is a plain read strobe.

Top module: `dcfifo_pflag`

## Requirements
- R1: In standard timing (captured when `fwft_sel`=0 at master reset), an `rd_en` sampled high on an `rclk` edge while words are stored loads the oldest word into `dout` on that edge. `rd_flag`=1 exactly when no words are stored. Words leave in write order.
- R2: In fall-through timing (`fwft_sel`=1), the oldest word appears on `dout` with `rd_flag`=1 and no `rd_en`. An `rd_en` high on an `rclk` edge while `rd_flag`=1 consumes that word. `dout` holds steady while `rd_en` is low.
- R3: The memory holds 2^AW words (16 by default). When it is full, `wr_flag` is 1 in standard timing and 0 in fall-through timing, and further writes are dropped without changing the stored data. In fall-through timing one more word can wait on `dout`.
- R4: In standard timing, a read while empty changes neither the read pointer nor `dout`.
- R5: `half_full`=1 when the write-side count of stored words exceeds 2^AW/2.
- R6: `almost_empty`=1 when the stored count is at most the almost-empty offset. In fall-through timing the word waiting on `dout` is not counted.
- R7: `almost_full`=1 when the stored count is at least 2^AW minus the almost-full offset.
- R8: A master reset loads both offsets with (`preset_sel`+1) * 2^AW/16.
- R9: A write-clock edge with `ld`=1 and `wr_en`=1 stores `din[AW-1:0]` as an offset and not as data. The stores alternate: almost-empty offset first, then almost-full offset.
- R10: Each write-clock edge with `ser_en`=1 shifts `ser_in` into the least significant end of the almost-empty offset and the almost-full offset joined together, with the almost-empty offset in the upper half. After 2*AW shifts, the first bit sent is the MSB of the almost-empty offset.
- R11: A partial reset empties the buffer and clears both pointers. It keeps both offsets and both captured modes.
- R12: When `async_sel`=1 at master reset, both almost flags are computed from the live pointers of both clock domains. A write or a read changes them directly after its own clock edge, with no synchroniser delay.
- R13: A retransmit pulse on `rclk` rewinds reading to the first word written since reset. In standard timing the next read returns that word. In fall-through timing that word is on `dout` right after the `rt` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to both clocks |
| prst_n | input | 1 | Partial reset, active low, synchronous to both clocks |
| fwft_sel | input | 1 | Timing style captured at master reset (1 = fall-through) |
| async_sel | input | 1 | Almost-flag style captured at master reset (1 = live pointers) |
| preset_sel | input | 3 | Offset preset index captured at master reset |
| wr_en | input | 1 | Write strobe |
| ld | input | 1 | Routes a write to the offset registers |
| din | input | 36 | Write data or parallel offset |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset bit |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than half the depth stored |
| almost_full | output | 1 | Almost-full indication |
| rd_en | input | 1 | Read strobe or ready signal |
| rt | input | 1 | Retransmit pulse |
| dout | output | 36 | Output register |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Almost-empty indication |

## Verification
The ordering function is tested with random bursts of writes and reads on two clocks of different periods, once per timing style. This shows pointer-crossing and back-pressure errors that directed fills cannot reach. Directed fills to exact counts next to every threshold separate the preset, parallel and serial offset paths, and check the half-full and full limits. The live-pointer flag style is told apart from the synchronised style by sampling a flag half a write period after a write: only the live style has moved by then. Retransmit and partial reset are run in both timing styles, so that a rewind that costs a cycle, or a mode that is lost on reset, shows up on `dout` and `rd_flag`.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    TIMING_STD  = 1'b0,
    TIMING_FWFT = 1'b1
  } timing_e;

  typedef struct packed {
    timing_e timing;
    logic    async_flags;
  } mode_t;
endpackage

// File: rtl/dcf_cfg.sv
module dcf_cfg
  import dcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic [2:0]    preset_sel,
  input  logic          fwft_sel,
  input  logic          async_sel,
  input  logic          par_we,
  input  logic [AW-1:0] par_val,
  input  logic          ser_en,
  input  logic          ser_in,
  output mode_t         mode,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  localparam int SHIFT = AW - 4;

  logic [AW-1:0] preset;
  logic          ld_af;

  always_comb preset = AW'({1'b0, preset_sel} + 4'd1) << SHIFT;

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      mode.timing      <= fwft_sel ? TIMING_FWFT : TIMING_STD;
      mode.async_flags <= async_sel;
      ae_off           <= preset;
      af_off           <= preset;
      ld_af            <= 1'b0;
    end else if (!prst_n) begin
      ld_af <= 1'b0;
    end else if (par_we) begin
      if (ld_af) af_off <= par_val;
      else       ae_off <= par_val;
      ld_af <= !ld_af;
    end else if (ser_en) begin
      {ae_off, af_off} <= {ae_off[AW-2:0], af_off, ser_in};
    end
  end

  AST_PRST_KEEPS_OFFSETS: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_off) && $stable(af_off) && $stable(mode))); // R11
endmodule

// File: rtl/dcf_wr.sv
module dcf_wr #(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        push_req,
  input  logic [AW:0] rgray_i,
  output logic [AW:0] wptr,
  output logic [AW:0] wgray,
  output logic [AW:0] wcount,
  output logic        full,
  output logic        half,
  output logic        mem_we
);
  localparam int          DEPTH  = 1 << AW;
  localparam logic [AW:0] D_CNT  = (AW+1)'(DEPTH);
  localparam logic [AW:0] H_CNT  = (AW+1)'(DEPTH / 2);

  logic [AW:0] rq1, rq2, rbin, wnxt;

  always_comb begin
    rbin[AW] = rq2[AW];
    for (int i = AW - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rq2[i];
  end

  always_comb begin
    wcount = wptr - rbin;
    full   = (wcount == D_CNT);
    half   = (wcount > H_CNT);
    mem_we = push_req && !full;
    wnxt   = wptr + (AW+1)'(mem_we);
  end

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      rq1   <= '0;
      rq2   <= '0;
      wptr  <= '0;
      wgray <= '0;
    end else begin
      rq1   <= rgray_i;
      rq2   <= rq1;
      wptr  <= wnxt;
      wgray <= wnxt ^ (wnxt >> 1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    (push_req && full) |=> $stable(wptr)); // R3
  AST_COUNT_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= D_CNT); // R3
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd #(
  parameter int AW = 4,
  parameter int W  = 36
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          ren,
  input  logic          rt,
  input  logic [AW:0]   wgray_i,
  input  logic [W-1:0]  rd_word,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rcount,
  output logic [W-1:0]  dout,
  output logic          out_valid,
  output logic          ram_empty
);
  logic [AW:0] wq1, wq2, wbin, rnxt;
  logic        load, valid_nxt;

  always_comb begin
    wbin[AW] = wq2[AW];
    for (int i = AW - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wq2[i];
  end

  always_comb begin
    rcount    = wbin - rptr;
    ram_empty = (rcount == '0);
    rnxt      = rptr;
    load      = 1'b0;
    valid_nxt = out_valid;
    rd_addr   = rptr[AW-1:0];
    if (rt) begin
      if (fwft && (wbin != '0)) begin
        rd_addr   = '0;
        load      = 1'b1;
        rnxt      = (AW+1)'(1);
        valid_nxt = 1'b1;
      end else begin
        rnxt      = '0;
        valid_nxt = 1'b0;
      end
    end else if (fwft) begin
      if (!ram_empty && (!out_valid || ren)) begin
        load      = 1'b1;
        rnxt      = rptr + 1'b1;
        valid_nxt = 1'b1;
      end else if (ren) begin
        valid_nxt = 1'b0;
      end
    end else if (ren && !ram_empty) begin
      load = 1'b1;
      rnxt = rptr + 1'b1;
    end
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      wq1       <= '0;
      wq2       <= '0;
      rptr      <= '0;
      rgray     <= '0;
      dout      <= '0;
      out_valid <= 1'b0;
    end else begin
      wq1       <= wgray_i;
      wq2       <= wq1;
      rptr      <= rnxt;
      rgray     <= rnxt ^ (rnxt >> 1);
      out_valid <= valid_nxt;
      if (load) dout <= rd_word;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && ram_empty && ren && !rt) |=> ($stable(rptr) && $stable(dout))); // R4
  AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && out_valid && !ren && !rt) |=> (out_valid && $stable(dout))); // R2
  AST_RT_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && rt) |=> (rptr == '0)); // R13
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcf_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 4
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         fwft_sel,
  input  logic         async_sel,
  input  logic [2:0]   preset_sel,
  input  logic         wr_en,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         ser_en,
  input  logic         ser_in,
  output logic         wr_flag,
  output logic         half_full,
  output logic         almost_full,
  input  logic         rd_en,
  input  logic         rt,
  output logic [W-1:0] dout,
  output logic         rd_flag,
  output logic         almost_empty
);
  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] D_CNT = (AW+1)'(DEPTH);

  logic          rst_n;
  mode_t         mode;
  logic          fwft;
  logic [AW-1:0] ae_off, af_off;
  logic [AW:0]   wptr, wgray, wcount, rptr, rgray, rcount, tcount;
  logic          full, half, mem_we, out_valid, ram_empty;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_word;
  logic [W-1:0]  mem [DEPTH];

  assign rst_n = mrst_n & prst_n;
  assign fwft  = (mode.timing == TIMING_FWFT);

  dcf_cfg #(.AW(AW)) cfg_i (
    .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .preset_sel(preset_sel),
    .fwft_sel(fwft_sel), .async_sel(async_sel), .par_we(ld && wr_en),
    .par_val(din[AW-1:0]), .ser_en(ser_en), .ser_in(ser_in),
    .mode(mode), .ae_off(ae_off), .af_off(af_off)
  );

  dcf_wr #(.AW(AW)) wr_i (
    .wclk(wclk), .rst_n(rst_n), .push_req(wr_en && !ld), .rgray_i(rgray),
    .wptr(wptr), .wgray(wgray), .wcount(wcount), .full(full), .half(half),
    .mem_we(mem_we)
  );

  dcf_rd #(.AW(AW), .W(W)) rd_i (
    .rclk(rclk), .rst_n(rst_n), .fwft(fwft), .ren(rd_en), .rt(rt),
    .wgray_i(wgray), .rd_word(rd_word), .rd_addr(rd_addr), .rptr(rptr),
    .rgray(rgray), .rcount(rcount), .dout(dout), .out_valid(out_valid),
    .ram_empty(ram_empty)
  );

  always_ff @(posedge wclk) begin
    if (mem_we) mem[wptr[AW-1:0]] <= din;
  end

  assign rd_word = mem[rd_addr];
  assign tcount  = wptr - rptr;

  always_comb begin
    wr_flag   = fwft ? !full : full;
    rd_flag   = fwft ? out_valid : ram_empty;
    half_full = half;
    if (mode.async_flags) begin
      almost_empty = (tcount <= {1'b0, ae_off});
      almost_full  = (tcount >= (D_CNT - {1'b0, af_off}));
    end else begin
      almost_empty = (rcount <= {1'b0, ae_off});
      almost_full  = (wcount >= (D_CNT - {1'b0, af_off}));
    end
  end
endmodule

// File: tb/dcfifo_pflag_tb_top.sv
`timescale 1ns/1ps
module dcfifo_pflag_tb_top;
  localparam int W  = 36;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1;
  logic fwft_sel = 1'b0, async_sel = 1'b0;
  logic [2:0] preset_sel = 3'd0;
  logic wr_en = 1'b0, ld = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
  logic [W-1:0] din = '0;
  logic rd_en = 1'b0, rt = 1'b0;
  logic wr_flag, half_full, almost_full, rd_flag, almost_empty;
  logic [W-1:0] dout;

  int nchk = 0, nfail = 0;
  logic fwft_now = 1'b0;
  logic [W-1:0] q [$];

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_pflag #(.W(W), .AW(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .async_sel(async_sel), .preset_sel(preset_sel),
    .wr_en(wr_en), .ld(ld), .din(din), .ser_en(ser_en), .ser_in(ser_in),
    .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full),
    .rd_en(rd_en), .rt(rt), .dout(dout), .rd_flag(rd_flag),
    .almost_empty(almost_empty)
  );

  function automatic logic [W-1:0] word_of(int i);
    logic [31:0] h;
    h = 32'(i) * 32'h9E37_79B1 + 32'h1234_5678;
    return {4'hA, h};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic master(logic f, logic a, logic [2:0] s);
    @(negedge wclk);
    fwft_sel = f; async_sel = a; preset_sel = s; mrst_n = 1'b0;
    wr_en = 0; ld = 0; ser_en = 0; rd_en = 0; rt = 0;
    fwft_now = f;
    repeat (3) @(negedge rclk);
    repeat (3) @(negedge wclk);
    mrst_n = 1'b1;
    settle();
  endtask

  task automatic partial();
    @(negedge wclk);
    prst_n = 1'b0;
    repeat (3) @(negedge rclk);
    repeat (3) @(negedge wclk);
    prst_n = 1'b1;
    settle();
  endtask

  task automatic wr(logic [W-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1; ld = 1'b0; din = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic ldp(logic [W-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1; ld = 1'b1; din = d;
    @(negedge wclk);
    wr_en = 1'b0; ld = 1'b0;
  endtask

  task automatic fill(int first, int n);
    for (int i = 0; i < n; i++) wr(word_of(first + i));
  endtask

  task automatic rd_std(output logic [W-1:0] d);
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    d = dout;
  endtask

  task automatic pulse_rd();
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_rt();
    @(negedge rclk);
    rt = 1'b1;
    @(negedge rclk);
    rt = 1'b0;
  endtask

  task automatic writer(int n, int base);
    int cnt = 0;
    while (cnt < n) begin
      @(negedge wclk);
      if (($urandom % 3) != 0 && (fwft_now ? wr_flag : !wr_flag)) begin
        wr_en = 1'b1; din = word_of(base + cnt);
        q.push_back(word_of(base + cnt));
        cnt++;
      end else begin
        wr_en = 1'b0;
      end
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic reader(int n, string req);
    int got = 0;
    logic pend = 1'b0;
    logic [W-1:0] exp = '0;
    while (got < n || pend) begin
      @(negedge rclk);
      rd_en = 1'b0;
      if (fwft_now) begin
        if (got < n && rd_flag && ($urandom % 3) != 0) begin
          check(req, dout, q.pop_front());
          rd_en = 1'b1;
          got++;
        end
      end else begin
        if (pend) begin
          check(req, dout, exp);
          pend = 1'b0;
        end
        if (got < n && !rd_flag && ($urandom % 3) != 0) begin
          rd_en = 1'b1;
          exp = q.pop_front();
          pend = 1'b1;
          got++;
        end
      end
    end
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd2024));

    // Reset state and presets, standard timing, synchronous flags
    master(1'b0, 1'b0, 3'd3);
    check("R1 empty after reset", rd_flag, 1);
    check("R3 not full after reset", wr_flag, 0);
    check("R5 half low after reset", half_full, 0);
    check("R6 almost-empty after reset", almost_empty, 1);
    check("R7 almost-full low after reset", almost_full, 0);
    fill(0, 4); settle();
    check("R8 preset ae at 4", almost_empty, 1);
    fill(4, 1); settle();
    check("R8 preset ae at 5", almost_empty, 0);
    fill(5, 3); settle();
    check("R5 half at 8", half_full, 0);
    fill(8, 1); settle();
    check("R5 half at 9", half_full, 1);
    fill(9, 2); settle();
    check("R7 af at 11", almost_full, 0);
    fill(11, 1); settle();
    check("R8 preset af at 12", almost_full, 1);
    fill(12, 4); settle();
    check("R3 full at depth", wr_flag, 1);
    wr(word_of(99)); settle();
    for (int i = 0; i < D; i++) begin
      rd_std(d);
      check("R1 R3 order after full", d, word_of(i));
    end
    check("R1 empty after drain", rd_flag, 1);
    pulse_rd(); pulse_rd();
    check("R4 dout kept on empty read", dout, word_of(D - 1));
    wr(word_of(50)); settle();
    rd_std(d);
    check("R4 pointer kept on empty read", d, word_of(50));

    // Random traffic, standard timing
    master(1'b0, 1'b0, 3'd0);
    fork
      writer(60, 200);
      reader(60, "R1 random order");
    join
    settle();
    check("R1 empty after random", rd_flag, 1);

    // Fall-through timing
    master(1'b1, 1'b0, 3'd0);
    check("R2 not ready after reset", rd_flag, 0);
    wr(word_of(300)); settle();
    check("R2 first word shown", rd_flag, 1);
    check("R2 first word value", dout, word_of(300));
    pulse_rd(); settle();
    check("R2 consumed", rd_flag, 0);
    fork
      writer(60, 400);
      reader(60, "R2 random order");
    join
    settle();
    fill(500, D + 1); settle();
    check("R3 fall-through no room", wr_flag, 0);
    check("R2 head held", dout, word_of(500));

    // Parallel offset load
    master(1'b0, 1'b0, 3'd0);
    ldp(36'd2); ldp(36'd3); settle();
    check("R9 load stores no data", rd_flag, 1);
    fill(0, 2); settle();
    check("R9 ae at 2", almost_empty, 1);
    fill(2, 1); settle();
    check("R9 ae at 3", almost_empty, 0);
    fill(3, 9); settle();
    check("R9 af at 12", almost_full, 0);
    fill(12, 1); settle();
    check("R9 af at 13", almost_full, 1);

    // Serial offset load then partial reset
    master(1'b0, 1'b0, 3'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge wclk);
      ser_en = 1'b1;
      ser_in = 1'(8'b0101_0001 >> (7 - i));
    end
    @(negedge wclk);
    ser_en = 1'b0;
    settle();
    fill(0, 5); settle();
    check("R10 ae at 5", almost_empty, 1);
    fill(5, 1); settle();
    check("R10 ae at 6", almost_empty, 0);
    fill(6, 8); settle();
    check("R10 af at 14", almost_full, 0);
    fill(14, 1); settle();
    check("R10 af at 15", almost_full, 1);
    partial();
    check("R11 empty after partial", rd_flag, 1);
    check("R11 af low after partial", almost_full, 0);
    fill(0, 5); settle();
    check("R11 ae kept at 5", almost_empty, 1);
    fill(5, 1); settle();
    check("R11 ae kept at 6", almost_empty, 0);
    check("R11 standard kept, no fall-through", dout, 0);

    master(1'b1, 1'b0, 3'd0);
    wr(word_of(700)); settle();
    partial();
    check("R11 output cleared", rd_flag, 0);
    wr(word_of(701)); settle();
    check("R11 fall-through kept", rd_flag, 1);
    check("R11 fall-through word", dout, word_of(701));

    // Live-pointer almost flags
    master(1'b0, 1'b1, 3'd3);
    fill(0, 4); settle();
    check("R12 ae at 4", almost_empty, 1);
    wr(word_of(4));
    check("R12 ae drops right after write", almost_empty, 0);
    fill(5, 6); settle();
    check("R12 af at 11", almost_full, 0);
    wr(word_of(11));
    check("R12 af rises right after write", almost_full, 1);
    rd_std(d);
    check("R12 af drops right after read", almost_full, 0);

    // Retransmit, standard timing
    master(1'b0, 1'b0, 3'd0);
    fill(0, 5); settle();
    rd_std(d); check("R13 first read", d, word_of(0));
    rd_std(d); check("R13 second read", d, word_of(1));
    pulse_rt();
    rd_std(d); check("R13 rewind to first", d, word_of(0));
    rd_std(d); check("R13 continues", d, word_of(1));

    // Retransmit, fall-through timing
    master(1'b1, 1'b0, 3'd0);
    fill(0, 3); settle();
    check("R13 head before", dout, word_of(0));
    pulse_rd();
    check("R13 next after consume", dout, word_of(1));
    pulse_rt();
    check("R13 fall-through rewind value", dout, word_of(0));
    check("R13 fall-through rewind ready", rd_flag, 1);

    finish_run();
  end
endmodule